// File: doc/BRIEF.md
# Two-Wire Bus Slave Address Matcher

This block listens to a two-wire serial bus as a slave and decides, for the first byte after every start or repeated start, whether that byte is addressed to this device. Both bus lines are brought into the system clock domain, and each bit is taken on a rising clock edge. The bits are assembled into a 7-bit address followed by a direction bit. The address is compared against a programmed own address, and a mask can drop any address bit from that compare. An enable widens the match to the all-zero general-call address.

When the address matches and acknowledging is allowed, the block pulls the data line low for the ninth clock. It releases the line on the falling clock edge that ends that clock and gives a one-cycle strobe at that moment. The direction and the general-call indication are then held on plain status outputs. Bytes that follow the address are left to other logic. This block ignores them until the next start.

`sda_oe` is an open-drain enable: 1 means the data pad is driven low and 0 means it is released. The system clock must run at least 8 times faster than the bus clock. There is no streaming data path, so every pin is a plain level or pulse.

Top module: `twb_addr_match`

## Requirements
- R1: After reset, `sda_oe`, `match_stb`, `match_rw` and `match_gc` are all 0.
- R2: A start is SDA falling while SCL is high. The eight data-line values taken on the next eight SCL rising edges form the address, most significant bit first, and then the direction bit. A direction bit of 1 means read and is reported on `match_rw`.
- R3: The address matches when every address bit equals the matching `own_addr` bit. Any bit whose `addr_mask` bit is 1 counts as equal whatever its value.
- R4: With `gc_en` = 1, the address 0x00 also matches. `match_gc` is set by a match on address 0x00 while `gc_en` = 1, and is cleared by any other match.
- R5: With `ack_en` = 0 at the eighth SCL rising edge, no address is acknowledged and no strobe is produced.
- R6: On a match, `sda_oe` goes to 1 after the SCL falling edge that ends the eighth clock and returns to 0 after the falling edge that ends the ninth clock. It is 1 throughout the ninth SCL high phase. On a non-match, `sda_oe` stays 0.
- R7: `match_stb` is a one-cycle pulse in the cycle in which `sda_oe` is released after an acknowledge. It occurs exactly once for each acknowledged address.
- R8: A repeated start, whether during address capture or after a completed address, restarts capture from the first address bit.
- R9: A stop (SDA rising while SCL is high) ends capture at once with no acknowledge. Bits clocked after a stop and before the next start are ignored.
- R10: Bytes clocked after the address byte are never acknowledged until the next start, even when their value equals a matching address.
- R11: `match_rw` and `match_gc` are updated only when a match is decided at the eighth SCL rising edge, and keep their values through non-matching addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| own_addr | input | 7 | Programmed own address |
| addr_mask | input | 7 | A 1 removes that address bit from the compare |
| gc_en | input | 1 | Also accept address 0x00 |
| ack_en | input | 1 | Allows any acknowledge at all |
| sda_oe | output | 1 | 1 = pull data line low |
| match_stb | output | 1 | One-cycle pulse when an acknowledged address completes |
| match_rw | output | 1 | Direction bit of the last match, 1 = read |
| match_gc | output | 1 | Last match was a general call |

## Verification
The bench works through mask and general-call combinations. These include a masked top bit and a masked bottom bit, a mismatch one bit away from the masked one, address 0x00 with the enable off, and an own address of zero. A design that compared masked bits, or that let the mask widen beyond its set bits, would acknowledge or reject the wrong one of these. Acknowledge disable is tried on an address that would otherwise match, so a design that ignored it would drive the line. Transfers are cut short by a stop and by a repeated start in the middle of the address, and a data byte equal to the own address follows a match. A design that kept its bit count across conditions, or re-armed after the first byte, would then acknowledge where it must not or strobe twice.

// File: rtl/twb_pkg.sv
package twb_pkg;

  // Line indices for the synchroniser array
  localparam int LN_SCL    = 0;
  localparam int LN_SDA    = 1;
  localparam int NUM_LINES = 2;

  // Address-phase controller states
  typedef enum logic [2:0] {
    ST_IDLE,   // no transfer in progress
    ST_ADDR,   // shifting address and direction bits
    ST_ARM,    // matched, waiting for end of eighth clock
    ST_ACK,    // driving acknowledge through ninth clock
    ST_SKIP    // rest of transfer is not ours to handle
  } twb_state_e;

endpackage

// File: rtl/twb_line_sync.sv
module twb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);

  // STAGES flops for metastability plus one to remember the last level
  logic [STAGES:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;   // idle bus is high
    else        sr <= {sr[STAGES-1:0], din};
  end

  assign lvl  = sr[STAGES-1];
  assign rise =  sr[STAGES-1] & ~sr[STAGES];
  assign fall = ~sr[STAGES-1] &  sr[STAGES];

endmodule

// File: rtl/twb_bus_cond.sv
module twb_bus_cond (
  input  logic scl_lvl,
  input  logic scl_rise,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_det,
  output logic stop_det
);

  // SCL must have been high in this and the previous sample
  logic scl_steady_hi;

  assign scl_steady_hi = scl_lvl & ~scl_rise;
  assign start_det     = sda_fall & scl_steady_hi;
  assign stop_det      = sda_rise & scl_steady_hi;

endmodule

// File: rtl/twb_addr_cmp.sv
module twb_addr_cmp #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] addr_mask,
  input  logic              gc_en,
  input  logic              ack_en,
  output logic              hit,
  output logic              gc_hit
);

  logic [ADDR_W-1:0] bit_ok;
  logic              own_hit;
  logic              zero_addr;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign bit_ok[i] = addr_mask[i] | (addr[i] == own_addr[i]);
  end

  assign own_hit   = &bit_ok;
  assign zero_addr = (addr == '0);
  assign gc_hit    = gc_en & zero_addr;
  assign hit       = ack_en & (own_hit | gc_hit);

endmodule

// File: rtl/twb_addr_fsm.sv
module twb_addr_fsm
  import twb_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              hit,
  input  logic              gc_hit,
  output logic [ADDR_W-1:0] addr_sr,
  output logic              sda_oe,
  output logic              match_stb,
  output logic              match_rw,
  output logic              match_gc
);

  localparam int BCW = $clog2(ADDR_W + 1);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(ADDR_W);

  twb_state_e     st;
  logic [BCW-1:0] bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bit_cnt   <= '0;
      addr_sr   <= '0;
      sda_oe    <= 1'b0;
      match_stb <= 1'b0;
      match_rw  <= 1'b0;
      match_gc  <= 1'b0;
    end else begin
      match_stb <= 1'b0;
      if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        st      <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: if (scl_rise) begin
            if (bit_cnt == LAST_BIT) begin
              // sda_lvl is the direction bit; addr_sr holds the address
              if (hit) begin
                st       <= ST_ARM;
                match_rw <= sda_lvl;
                match_gc <= gc_hit;
              end else begin
                st <= ST_SKIP;
              end
            end else begin
              addr_sr <= {addr_sr[ADDR_W-2:0], sda_lvl};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_ARM: if (scl_fall) begin
            st     <= ST_ACK;
            sda_oe <= 1'b1;
          end
          ST_ACK: if (scl_fall) begin
            st        <= ST_SKIP;
            sda_oe    <= 1'b0;
            match_stb <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R7: strobe lasts a single cycle
  a_r7_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    match_stb |=> !match_stb);

  // R7: strobe marks the release of a driven acknowledge
  a_r7_stb_after_drive: assert property (@(posedge clk) disable iff (!rst_n)
    match_stb |-> (!sda_oe && $past(sda_oe)));

  // R6: drive begins only after an SCL falling edge
  a_r6_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R9: stop returns to idle with the line released
  a_r9_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE && !sda_oe));

  // R8: start restarts capture from bit zero
  a_r8_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (st == ST_ADDR && bit_cnt == '0));

endmodule

// File: rtl/twb_addr_match.sv
module twb_addr_match
  import twb_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] addr_mask,
  input  logic              gc_en,
  input  logic              ack_en,
  output logic              sda_oe,
  output logic              match_stb,
  output logic              match_rw,
  output logic              match_gc
);

  logic [NUM_LINES-1:0] raw, lvl, rise, fall;
  logic                 start_det, stop_det;
  logic                 hit, gc_hit;
  logic [ADDR_W-1:0]    addr_sr;

  assign raw[LN_SCL] = scl_i;
  assign raw[LN_SDA] = sda_i;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_sync
    twb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw[g]),
      .lvl  (lvl[g]),
      .rise (rise[g]),
      .fall (fall[g])
    );
  end

  twb_bus_cond u_cond (
    .scl_lvl  (lvl[LN_SCL]),
    .scl_rise (rise[LN_SCL]),
    .sda_rise (rise[LN_SDA]),
    .sda_fall (fall[LN_SDA]),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  twb_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .addr     (addr_sr),
    .own_addr (own_addr),
    .addr_mask(addr_mask),
    .gc_en    (gc_en),
    .ack_en   (ack_en),
    .hit      (hit),
    .gc_hit   (gc_hit)
  );

  twb_addr_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (rise[LN_SCL]),
    .scl_fall (fall[LN_SCL]),
    .sda_lvl  (lvl[LN_SDA]),
    .start_det(start_det),
    .stop_det (stop_det),
    .hit      (hit),
    .gc_hit   (gc_hit),
    .addr_sr  (addr_sr),
    .sda_oe   (sda_oe),
    .match_stb(match_stb),
    .match_rw (match_rw),
    .match_gc (match_gc)
  );

  // R6: the acknowledge is held while SCL is high
  a_r6_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !rise[LN_SCL] && lvl[LN_SCL]) |=> (sda_oe || $past(fall[LN_SCL]) || fall[LN_SCL] || !lvl[LN_SCL]));

endmodule

// File: tb/sim_twb_addr_match.sv
module sim_twb_addr_match;

  localparam int H = 10; // system clocks per SCL half period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [6:0] own_addr = '0;
  logic [6:0] addr_mask = '0;
  logic       gc_en = 1'b0;
  logic       ack_en = 1'b0;
  logic       sda_oe, match_stb, match_rw, match_gc;
  logic       sda_bus;

  int nchk = 0;
  int nerr = 0;
  int stb_cnt = 0;
  logic cap_rw = 1'b0, cap_gc = 1'b0, oe_seen = 1'b0, done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  assign sda_bus = m_sda & ~sda_oe;

  twb_addr_match u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .own_addr(own_addr), .addr_mask(addr_mask), .gc_en(gc_en), .ack_en(ack_en),
    .sda_oe(sda_oe), .match_stb(match_stb), .match_rw(match_rw), .match_gc(match_gc)
  );

  always @(negedge clk) begin
    if (match_stb) begin
      stb_cnt <= stb_cnt + 1;
      cap_rw  <= match_rw;
      cap_gc  <= match_gc;
    end
    if (sda_oe) oe_seen <= 1'b1;
  end

  // own, mask, gc_en, ack_en, byte, exp_ack, exp_rw, exp_gc
  localparam int NV = 13;
  localparam logic [26:0] VEC [NV] = '{
    {7'h3A, 7'h00, 1'b0, 1'b1, 8'h74, 1'b1, 1'b0, 1'b0}, // R2 write
    {7'h3A, 7'h00, 1'b0, 1'b1, 8'h75, 1'b1, 1'b1, 1'b0}, // R2 read
    {7'h3A, 7'h00, 1'b0, 1'b1, 8'h76, 1'b0, 1'b0, 1'b0}, // R3 lsb off
    {7'h3A, 7'h01, 1'b0, 1'b1, 8'h77, 1'b1, 1'b1, 1'b0}, // R3 lsb masked
    {7'h3A, 7'h40, 1'b0, 1'b1, 8'hF4, 1'b1, 1'b0, 1'b0}, // R3 msb masked
    {7'h3A, 7'h40, 1'b0, 1'b1, 8'h34, 1'b0, 1'b0, 1'b0}, // R3 unmasked bit off
    {7'h3A, 7'h00, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1}, // R4 general call
    {7'h3A, 7'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0}, // R4 gc disabled
    {7'h3A, 7'h00, 1'b1, 1'b0, 8'h74, 1'b0, 1'b0, 1'b0}, // R5 own, ack off
    {7'h3A, 7'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R5 gc, ack off
    {7'h00, 7'h00, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0}, // R4 own zero, not gc
    {7'h55, 7'h7F, 1'b0, 1'b1, 8'h55, 1'b1, 1'b1, 1'b0}, // R3 all masked
    {7'h3A, 7'h00, 1'b1, 1'b1, 8'h01, 1'b1, 1'b1, 1'b1}  // R4 gc read
  };

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp_v);
    nchk++;
    if (act != exp_v) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic start_c();
    m_sda = 1'b1; wt(H);
    scl = 1'b1;   wt(H);
    m_sda = 1'b0; wt(H);
    scl = 1'b0;   wt(H);
  endtask

  task automatic stop_c();
    m_sda = 1'b0; wt(H);
    scl = 1'b1;   wt(H);
    m_sda = 1'b1; wt(H);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wt(H);
    scl = 1'b1; wt(H);
    scl = 1'b0;
  endtask

  task automatic ninth(output logic ack);
    wt(H);
    m_sda = 1'b1; wt(H);
    scl = 1'b1; wt(H/2);
    ack = sda_oe;
    wt(H/2);
    scl = 1'b0; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    ninth(ack);
  endtask

  task automatic cfg(input logic [6:0] o, input logic [6:0] m, input logic g, input logic a);
    own_addr = o; addr_mask = m; gc_en = g; ack_en = a;
  endtask

  initial begin
    logic ack;
    int   s0;
    wt(5);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 match_stb", match_stb, 0);
    chk("R1 match_rw", match_rw, 0);
    chk("R1 match_gc", match_gc, 0);
    rst_n = 1'b1;
    wt(5);

    for (int k = 0; k < NV; k++) begin
      logic [26:0] v;
      v = VEC[k];
      cfg(v[26:20], v[19:13], v[12], v[11]);
      s0 = stb_cnt;
      start_c();
      send_byte(v[10:3], ack);
      stop_c();
      chk($sformatf("R3 R4 R5 vec%0d ack", k), ack, v[2]);
      chk($sformatf("R7 vec%0d strobes", k), stb_cnt - s0, v[2] ? 1 : 0);
      chk($sformatf("R6 vec%0d released", k), sda_oe, 0);
      if (v[2]) begin
        chk($sformatf("R2 vec%0d rw", k), cap_rw, v[1]);
        chk($sformatf("R4 vec%0d gc", k), cap_gc, v[0]);
      end
    end

    // R11: a non-matching address keeps the previous direction
    cfg(7'h3A, 7'h00, 1'b0, 1'b1);
    start_c(); send_byte(8'h75, ack); stop_c();
    start_c(); send_byte(8'h76, ack); stop_c();
    chk("R11 rw held", match_rw, 1);
    chk("R11 nack", ack, 0);

    // R10: data byte equal to own address is not acknowledged
    s0 = stb_cnt;
    start_c(); send_byte(8'h74, ack);
    chk("R10 address ack", ack, 1);
    oe_seen = 1'b0;
    send_byte(8'h74, ack);
    chk("R10 data ack", ack, 0);
    chk("R10 no drive in data", oe_seen, 0);
    stop_c();
    chk("R10 strobes", stb_cnt - s0, 1);

    // R9: stop mid-address, then bits without a start
    s0 = stb_cnt;
    oe_seen = 1'b0;
    start_c();
    for (int i = 7; i >= 4; i--) send_bit(1'(8'h74 >> i));
    wt(H);
    stop_c();
    for (int i = 7; i >= 0; i--) send_bit(1'(8'h74 >> i));
    ninth(ack);
    stop_c();
    chk("R9 no ack after stop", ack, 0);
    chk("R9 no drive", oe_seen, 0);
    chk("R9 no strobe", stb_cnt - s0, 0);

    // R8: repeated start during address capture
    s0 = stb_cnt;
    start_c();
    for (int i = 7; i >= 5; i--) send_bit(1'(8'h76 >> i));
    wt(H);
    start_c();
    send_byte(8'h75, ack);
    chk("R8 restart ack", ack, 1);
    chk("R8 restart rw", cap_rw, 1);
    // R8: repeated start after a completed address
    start_c();
    send_byte(8'h74, ack);
    stop_c();
    chk("R8 second ack", ack, 1);
    chk("R8 second rw", cap_rw, 0);
    chk("R8 strobes", stb_cnt - s0, 2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule